// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block decides whether one memory access passes legacy segment protection before any page translation takes place. Each request carries a linear address, a byte count, the access direction, a store-check flag and an address-size override. The request also carries a description of the segment in use: its index, selector, base, limit and rights (readable, writable, grows-down), along with the code segment's default-size bit and two processor mode bits. The block answers with a registered pass or fault verdict one cycle after the request. A fault is always a general-protection fault with error code zero.

The offset into the segment is the linear address minus the base. It is cut to 16 or 32 bits, depending on the code segment's default size and the override flag. Both the first and the last byte of the access are tested against the limit. The test is inverted for segments that grow down. The sum that forms the last-byte offset is one bit wider than the offset, so an access that runs past the top of the offset space still faults.

The segment index space is split by two parameters. One names the ordinary data segments, which get the rights and grow-down handling. The other names the system segments, which are exempt from the null-selector test.

Top module: `seg_guard`

## Requirements
- R1: A request presented with `req_valid` high produces `rsp_valid` high exactly one clock later. A cycle without a request produces `rsp_valid` low one clock later.
- R2: When `prot_on` is low or `long_mode` is high, every request passes (`rsp_fault` = 0) whatever its selector, rights or offset.
- R3: A selector of zero faults, unless the segment index is in the null-exempt set (indices 6 and 7 by default).
- R4: For a data segment (indices 0 to 5 by default) whose writable bit is clear, a write faults. A read with the store-check flag set also faults. A plain read without the flag passes.
- R5: For a data segment whose readable bit is clear, a read faults. A write to that segment is not affected by the readable bit.
- R6: For a segment index outside the data set, the readable, writable and grow-down bits have no effect on the verdict.
- R7: The offset is 16 bits wide when `cs_big` and `size_ovr` are equal (both 0 or both 1), and 32 bits wide when they differ.
- R8: The offset is (`lin_addr` − `seg_base`) modulo 2^width. A linear address below the base therefore gives a large offset.
- R9: For a normal segment, the access faults when the first-byte offset or the last-byte offset (offset + size − 1) is greater than `seg_limit`.
- R10: For a data segment with the grow-down bit set, the access faults when the first-byte offset or the last-byte offset is less than or equal to `seg_limit`.
- R11: The last-byte offset is computed one bit wider than the offset width. An access whose last byte passes the top of the 16-bit or 32-bit offset space is compared without wrap-around.
- R12: `rsp_err` is zero on every response, including faults.
- R13: The synchronous reset `rst` drives `rsp_valid` and `rsp_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| lin_addr | input | 32 | Linear address of the first byte |
| acc_bytes | input | 4 | Access size in bytes (1 or more) |
| acc_write | input | 1 | 1 = write, 0 = read |
| store_chk | input | 1 | Read that must also be writable |
| size_ovr | input | 1 | Address-size override flag |
| seg_idx | input | 3 | Segment index |
| seg_sel | input | 16 | Segment selector |
| seg_base | input | 32 | Segment base |
| seg_limit | input | 32 | Segment limit (inclusive) |
| seg_rd_ok | input | 1 | Segment readable |
| seg_wr_ok | input | 1 | Segment writable |
| seg_grow_dn | input | 1 | Segment grows down |
| cs_big | input | 1 | Code segment default size is 32-bit |
| prot_on | input | 1 | Protected mode enabled |
| long_mode | input | 1 | 64-bit mode active |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | General-protection fault |
| rsp_err | output | 16 | Fault error code |

## Verification
The assertions check four things on every cycle: the one-cycle valid pipeline, the bypass in the disabled and 64-bit modes, the null-selector fault for non-exempt segments, and the rights faults for data segments. Only the bench's scenarios show the arithmetic. This covers the choice between the 16-bit and 32-bit offset widths, the modulo subtraction below the base, the first-byte and last-byte comparisons at the exact limit boundary, the inverted test for grow-down segments, and the carry out of the last-byte sum that must not wrap.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic grow_dn;
  } seg_rights_t;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 16,
  parameter int SIZE_W  = 4
) (
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [SIZE_W-1:0] acc_bytes,
  input  logic              use_short,
  output logic [ADDR_W-1:0] first_off,
  output logic [ADDR_W:0]   last_off
);
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] diff;
  logic [EXT_W-1:0]  size_ext;

  assign diff     = lin_addr - seg_base;
  assign size_ext = {{(EXT_W-SIZE_W){1'b0}}, acc_bytes};

  always_comb begin
    if (use_short)
      first_off = {{(ADDR_W-SHORT_W){1'b0}}, diff[SHORT_W-1:0]};
    else
      first_off = diff;
  end

  // One extra bit keeps the carry out of the last-byte sum.
  assign last_off = {1'b0, first_off} + size_ext - EXT_W'(1);
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_off,
  input  logic [ADDR_W:0]   last_off,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              grow_dn,
  output logic              lim_viol
);
  logic first_above;
  logic last_above;

  assign first_above = first_off > seg_limit;
  assign last_above  = last_off > {1'b0, seg_limit};

  always_comb begin
    if (grow_dn)
      lim_viol = !first_above || !last_above;
    else
      lim_viol = first_above || last_above;
  end
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_guard_pkg::*;
#(
  parameter int          SEG_W       = 3,
  parameter int          SEL_W       = 16,
  parameter logic [(1<<SEG_W)-1:0] DATA_MASK   = 8'h3F,
  parameter logic [(1<<SEG_W)-1:0] EXEMPT_MASK = 8'hC0
) (
  input  logic [SEG_W-1:0] seg_idx,
  input  logic [SEL_W-1:0] seg_sel,
  input  seg_rights_t      rights,
  input  acc_kind_e        kind,
  input  logic             store_chk,
  output logic             is_data,
  output logic             null_flt,
  output logic             rights_flt
);
  logic exempt;
  logic wr_flt;
  logic rd_flt;

  assign is_data  = DATA_MASK[seg_idx];
  assign exempt   = EXEMPT_MASK[seg_idx];
  assign null_flt = !exempt && (seg_sel == '0);

  assign wr_flt     = !rights.wr_ok && ((kind == ACC_WRITE) || store_chk);
  assign rd_flt     = !rights.rd_ok && (kind == ACC_READ);
  assign rights_flt = is_data && (wr_flt || rd_flt);
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int SEG_W  = 3,
  parameter int SEL_W  = 16,
  parameter int ERR_W  = 16,
  parameter logic [(1<<SEG_W)-1:0] DATA_MASK   = 8'h3F,
  parameter logic [(1<<SEG_W)-1:0] EXEMPT_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [SIZE_W-1:0] acc_bytes,
  input  logic              acc_write,
  input  logic              store_chk,
  input  logic              size_ovr,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              seg_rd_ok,
  input  logic              seg_wr_ok,
  input  logic              seg_grow_dn,
  input  logic              cs_big,
  input  logic              prot_on,
  input  logic              long_mode,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ERR_W-1:0]  rsp_err
);
  localparam int SHORT_W = ADDR_W / 2;
  localparam logic [ERR_W-1:0] GP_CODE = '0;

  seg_rights_t       rights;
  acc_kind_e         kind;
  logic              use_short;
  logic              is_data;
  logic              null_flt;
  logic              rights_flt;
  logic              lim_viol;
  logic              checks_on;
  logic              fault_c;
  logic [ADDR_W-1:0] first_off;
  logic [ADDR_W:0]   last_off;

  assign rights    = '{rd_ok: seg_rd_ok, wr_ok: seg_wr_ok, grow_dn: seg_grow_dn};
  assign kind      = acc_write ? ACC_WRITE : ACC_READ;
  assign use_short = (cs_big == size_ovr);
  assign checks_on = prot_on && !long_mode;

  seg_rights_chk #(
    .SEG_W(SEG_W), .SEL_W(SEL_W),
    .DATA_MASK(DATA_MASK), .EXEMPT_MASK(EXEMPT_MASK)
  ) u_rights (
    .seg_idx(seg_idx), .seg_sel(seg_sel), .rights(rights), .kind(kind),
    .store_chk(store_chk), .is_data(is_data), .null_flt(null_flt),
    .rights_flt(rights_flt)
  );

  seg_offset_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .SIZE_W(SIZE_W)) u_off (
    .lin_addr(lin_addr), .seg_base(seg_base), .acc_bytes(acc_bytes),
    .use_short(use_short), .first_off(first_off), .last_off(last_off)
  );

  seg_limit_cmp #(.ADDR_W(ADDR_W)) u_lim (
    .first_off(first_off), .last_off(last_off), .seg_limit(seg_limit),
    .grow_dn(rights.grow_dn && is_data), .lim_viol(lim_viol)
  );

  assign fault_c = checks_on && (null_flt || rights_flt || lim_viol);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && fault_c;
      rsp_err   <= GP_CODE;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!prot_on || long_mode)) |=> !rsp_fault);
  a_r3_null_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && checks_on && seg_sel == '0 && !EXEMPT_MASK[seg_idx]) |=> rsp_fault);
  a_r4_write_protect: assert property (@(posedge clk) disable iff (rst)
    (req_valid && checks_on && DATA_MASK[seg_idx] && !seg_wr_ok &&
     (acc_write || store_chk)) |=> rsp_fault);
  a_r5_read_protect: assert property (@(posedge clk) disable iff (rst)
    (req_valid && checks_on && DATA_MASK[seg_idx] && !seg_rd_ok && !acc_write)
    |=> rsp_fault);
endmodule

// File: tb/test_seg_guard.sv
`timescale 1ns/1ps
module test_seg_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] lin_addr;
  logic [3:0]  acc_bytes;
  logic        acc_write, store_chk, size_ovr;
  logic [2:0]  seg_idx;
  logic [15:0] seg_sel;
  logic [31:0] seg_base, seg_limit;
  logic        seg_rd_ok, seg_wr_ok, seg_grow_dn;
  logic        cs_big, prot_on, long_mode;
  logic        rsp_valid, rsp_fault;
  logic [15:0] rsp_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_guard i_seg_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .lin_addr(lin_addr),
    .acc_bytes(acc_bytes), .acc_write(acc_write), .store_chk(store_chk),
    .size_ovr(size_ovr), .seg_idx(seg_idx), .seg_sel(seg_sel),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_rd_ok(seg_rd_ok),
    .seg_wr_ok(seg_wr_ok), .seg_grow_dn(seg_grow_dn), .cs_big(cs_big),
    .prot_on(prot_on), .long_mode(long_mode), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Baseline: 32-bit offsets, data segment 3, base 0x1000, limit 0xFFFF.
  task automatic defaults();
    prot_on = 1; long_mode = 0; cs_big = 1; size_ovr = 0;
    seg_idx = 3; seg_sel = 16'h0010; seg_base = 32'h1000; seg_limit = 32'hFFFF;
    seg_rd_ok = 1; seg_wr_ok = 1; seg_grow_dn = 0;
    lin_addr = 32'h1010; acc_bytes = 4; acc_write = 0; store_chk = 0;
  endtask

  // Called at a falling edge; leaves the bench at the falling edge after the result.
  task automatic run(input string tag, input logic exp_fault);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " fault"}, {31'b0, rsp_fault}, {31'b0, exp_fault});
    check({tag, " R12 err"}, {16'b0, rsp_err}, 32'd0);
  endtask

  task automatic t_reset_and_latency();
    check("R13 reset valid", {31'b0, rsp_valid}, 0);
    check("R13 reset fault", {31'b0, rsp_fault}, 0);
    defaults();
    run("R1 basic pass", 0);
    @(posedge clk); @(negedge clk);
    check("R1 idle gives no valid", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_limit_normal();
    defaults(); lin_addr = 32'h1000 + 32'hFFFC; run("R9 last byte at limit", 0);
    defaults(); lin_addr = 32'h1000 + 32'hFFFD; run("R9 last byte past limit", 1);
    defaults(); lin_addr = 32'h1000 + 32'h10000; acc_bytes = 1; run("R9 first byte past limit", 1);
  endtask

  task automatic t_width_and_offset();
    defaults(); lin_addr = 32'h0FFF; acc_bytes = 1; run("R8 below base 32-bit", 1);
    defaults(); cs_big = 0; lin_addr = 32'h0FFF; acc_bytes = 1; run("R8 below base 16-bit", 0);
    defaults(); size_ovr = 1; lin_addr = 32'h1000 + 32'h12345; acc_bytes = 1;
    run("R7 both set -> 16-bit", 0);
    defaults(); cs_big = 0; size_ovr = 1; lin_addr = 32'h1000 + 32'h12345; acc_bytes = 1;
    run("R7 differ -> 32-bit", 1);
  endtask

  task automatic t_wrap();
    defaults(); cs_big = 0; lin_addr = 32'h1000 + 32'hFFFE; run("R11 16-bit carry", 1);
    defaults(); seg_limit = 32'hFFFFFFFF; lin_addr = 32'h1000 + 32'hFFFFFFFE;
    run("R11 32-bit carry", 1);
    defaults(); seg_limit = 32'hFFFFFFFF; lin_addr = 32'h1000 + 32'hFFFFFFFC;
    run("R11 32-bit top fits", 0);
  endtask

  task automatic t_grow_down();
    defaults(); seg_grow_dn = 1; seg_limit = 32'h0FFF; lin_addr = 32'h3000; run("R10 above limit", 0);
    defaults(); seg_grow_dn = 1; seg_limit = 32'h0FFF; lin_addr = 32'h1FFF; acc_bytes = 1;
    run("R10 at limit", 1);
    defaults(); seg_grow_dn = 1; seg_limit = 32'h0FFF; lin_addr = 32'h1FFE; run("R10 straddles limit", 1);
    defaults(); seg_grow_dn = 1; seg_limit = 32'h0FFF; lin_addr = 32'h2000; run("R10 just above", 0);
  endtask

  task automatic t_null_sel();
    defaults(); seg_sel = 0; run("R3 null data segment", 1);
    defaults(); seg_sel = 0; seg_idx = 6; run("R3 null exempt segment", 0);
  endtask

  task automatic t_rights();
    defaults(); seg_wr_ok = 0; acc_write = 1; run("R4 write to read-only", 1);
    defaults(); seg_wr_ok = 0; store_chk = 1; run("R4 store-check read", 1);
    defaults(); seg_wr_ok = 0; run("R4 plain read", 0);
    defaults(); seg_rd_ok = 0; run("R5 read of exec-only", 1);
    defaults(); seg_rd_ok = 0; acc_write = 1; run("R5 write unaffected", 0);
    defaults(); seg_idx = 6; seg_rd_ok = 0; seg_wr_ok = 0; acc_write = 1;
    run("R6 rights ignored on system seg", 0);
    defaults(); seg_idx = 7; seg_grow_dn = 1; run("R6 grow-down ignored on system seg", 0);
  endtask

  task automatic t_bypass();
    defaults(); prot_on = 0; seg_sel = 0; seg_rd_ok = 0; lin_addr = 32'h0; run("R2 protection off", 0);
    defaults(); long_mode = 1; seg_sel = 0; seg_wr_ok = 0; acc_write = 1; lin_addr = 32'h0;
    run("R2 long mode", 0);
  endtask

  initial begin
    defaults();
    req_valid = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset_and_latency();
    t_limit_normal();
    t_width_and_offset();
    t_wrap();
    t_grow_down();
    t_null_sel();
    t_rights();
    t_bypass();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule